// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a virtual byte address into a physical address with a single-level page table. The table is kept in a small internal store. A configuration port writes entries one at a time. A context register selects which per-process slice of that store is active, so the tables of several processes sit side by side. The context register is reloaded whenever the running process changes.

A requester presents an address, an access kind (read, write or execute) and a privilege flag (user or kernel) under a valid/ready handshake. One cycle after the request is accepted, the block pulses a response. The response carries either the translated address or a single fault code. The entry is checked in a fixed order: the slot must hold an entry, the page must be mapped, the access must be permitted, and the frame must be resident. The first check that fails decides the code. Resolving a fault is left to software.

Top module: `pt_translator`

## Requirements
- R1: On success the response address is the entry's frame number in the upper bits, joined with the low PAGE_BITS of the virtual address passed through unchanged. The response fault code is 0.
- R2: An entry whose exists flag (entry bit PFN_BITS+4) is clear gives fault code 1, missing entry.
- R3: An entry that exists but has its valid flag (bit PFN_BITS+5) clear gives fault code 2, invalid page.
- R4: A protection fault gives fault code 3. It is raised when any of these holds:
  - the access kind's permission bit is clear. The access kinds are read=0, write=1 and exec=2. Their permission bits are r at PFN_BITS+2, w at PFN_BITS+1 and x at PFN_BITS.
  - a user-mode access (kernel flag 0) meets an entry whose user flag (bit PFN_BITS+3) is clear.
  - the access code is 3.
- R5: A valid, permitted entry whose present flag (bit PFN_BITS+6) is clear gives fault code 4, page not resident.
- R6: When several checks fail, only the first is reported, in the order missing, invalid, protection, not resident.
- R7: The table slot used is {context, virtual page number}. Loading a new context makes the same virtual page resolve through a different entry.
- R8: A request accepted on a clock edge (valid and ready both high) produces exactly one rsp_valid pulse in the following cycle. Back-to-back requests give back-to-back responses, and no response appears without an acceptance.
- R9: In a cycle where the table is written or the context is reloaded, req_ready is low. The change applies to every request accepted afterwards.
- R10: After reset these hold:
  - rsp_valid is low and req_ready is high.
  - the context is 0.
  - every entry is clear, so any request faults with code 1.
- R11: Several virtual pages may map to the same frame, and each of them yields that frame.
- R12: A faulted response drives a physical address of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | CTX_BITS+VPN_BITS | Slot written, {context, page} |
| cfg_entry | input | PFN_BITS+7 | Entry value {present, valid, exists, user, r, w, x, frame} |
| ctx_we | input | 1 | Context register load strobe |
| ctx_sel | input | CTX_BITS | New context number |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_vaddr | input | VPN_BITS+PAGE_BITS | Virtual byte address |
| req_access | input | 2 | 0 read, 1 write, 2 exec, 3 reserved |
| req_kernel | input | 1 | 1 kernel mode, 0 user mode |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | PFN_BITS+PAGE_BITS | Physical address, zero on fault |
| rsp_fault | output | 3 | 0 ok, 1 missing, 2 invalid, 3 protection, 4 not resident |

## Verification
A table write or a context reload can land in the same cycle as a request that is waiting to be looked up. The block settles this by holding off the request, so the conflict is the case to judge. The bench provokes it by raising req_valid in the very cycle it writes an entry or switches context. It checks that req_ready is low there and that no response follows. It then confirms that the next accepted request to that slot sees the new entry or the new context.

// File: rtl/pt_pkg.sv
// Shared types for the page table translator.
// Assumes: fault codes and access codes are fixed encodings seen at the ports.
package pt_pkg;
    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_MISSING = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_PROT    = 3'd3,
        FLT_ABSENT  = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    localparam int FLAG_BITS = 7;

    // Flag group that sits above the frame number inside an entry.
    typedef struct packed {
        logic present;
        logic valid;
        logic exists;
        logic user_ok;
        logic can_r;
        logic can_w;
        logic can_x;
    } pte_flags_t;
endpackage

// File: rtl/pt_table.sv
// Entry store for all contexts: one write port, one combinational read port.
// Assumes: a write and a read of the same slot never need forwarding,
// because the top holds requests off during writes.
module pt_table #(
    parameter int IDX_BITS = 6,
    parameter int ENT_W    = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic [ENT_W-1:0]    wr_data,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic [ENT_W-1:0]    rd_data
);
    localparam int DEPTH = 1 << IDX_BITS;

    logic [ENT_W-1:0] mem_q [DEPTH];

    // Clear every slot on reset, otherwise take the configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Present the addressed slot to the checker.
    always_comb rd_data = mem_q[rd_idx];
endmodule

// File: rtl/pt_check.sv
// Ordered entry checker: missing, invalid, protection, not resident.
// Assumes: entry layout {present, valid, exists, user_ok, r, w, x, frame}.
module pt_check
    import pt_pkg::*;
#(
    parameter int PFN_BITS = 8,
    localparam int ENT_W   = PFN_BITS + FLAG_BITS
) (
    input  logic [ENT_W-1:0]    entry,
    input  logic [1:0]          access,
    input  logic                kernel,
    output logic [2:0]          fault,
    output logic [PFN_BITS-1:0] frame
);
    pte_flags_t flags;
    logic       perm_ok;
    logic       mode_ok;

    // Split the entry into flags and frame number.
    always_comb begin
        flags = pte_flags_t'(entry[ENT_W-1 -: FLAG_BITS]);
        frame = entry[PFN_BITS-1:0];
    end

    // Pick the permission bit that matches the access kind.
    always_comb begin
        unique case (access_e'(access))
            ACC_READ:  perm_ok = flags.can_r;
            ACC_WRITE: perm_ok = flags.can_w;
            ACC_EXEC:  perm_ok = flags.can_x;
            default:   perm_ok = 1'b0;
        endcase
        mode_ok = kernel | flags.user_ok;
    end

    // Report only the first failing check, in fixed priority.
    always_comb begin
        if (!flags.exists)                fault = FLT_MISSING;
        else if (!flags.valid)            fault = FLT_INVALID;
        else if (!(perm_ok && mode_ok))   fault = FLT_PROT;
        else if (!flags.present)          fault = FLT_ABSENT;
        else                              fault = FLT_NONE;
    end
endmodule

// File: rtl/pt_translator.sv
// Single-level page table translator with per-context tables.
// Accepts a request when valid and ready meet, answers one cycle later.
// Assumes: table writes and context loads take priority over lookups, so
// req_ready drops in those cycles.
module pt_translator
    import pt_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int VPN_BITS  = 4,
    parameter int CTX_BITS  = 2,
    parameter int PFN_BITS  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CTX_BITS+VPN_BITS-1:0]  cfg_idx,
    input  logic [PFN_BITS+6:0]           cfg_entry,
    input  logic                          ctx_we,
    input  logic [CTX_BITS-1:0]           ctx_sel,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [VPN_BITS+PAGE_BITS-1:0] req_vaddr,
    input  logic [1:0]                    req_access,
    input  logic                          req_kernel,
    output logic                          rsp_valid,
    output logic [PFN_BITS+PAGE_BITS-1:0] rsp_paddr,
    output logic [2:0]                    rsp_fault
);
    localparam int IDX_BITS = CTX_BITS + VPN_BITS;
    localparam int ENT_W    = PFN_BITS + FLAG_BITS;
    localparam int PA_W     = PFN_BITS + PAGE_BITS;

    logic [CTX_BITS-1:0] ctx_q;
    logic [IDX_BITS-1:0] rd_idx;
    logic [ENT_W-1:0]    rd_entry;
    logic [2:0]          chk_fault;
    logic [PFN_BITS-1:0] chk_frame;
    logic                accept;

    // Hold off lookups while the table or the context is changing.
    always_comb begin
        req_ready = !(cfg_we || ctx_we);
        accept    = req_valid && req_ready;
        rd_idx    = {ctx_q, req_vaddr[PAGE_BITS +: VPN_BITS]};
    end

    // Context register: selects the active process's slice of the table.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctx_q <= '0;
        else if (ctx_we) ctx_q <= ctx_sel;
    end

    pt_table #(
        .IDX_BITS (IDX_BITS),
        .ENT_W    (ENT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_entry),
        .rd_idx  (rd_idx),
        .rd_data (rd_entry)
    );

    pt_check #(
        .PFN_BITS (PFN_BITS)
    ) u_check (
        .entry  (rd_entry),
        .access (req_access),
        .kernel (req_kernel),
        .fault  (chk_fault),
        .frame  (chk_frame)
    );

    // Register the response of an accepted request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_fault <= chk_fault;
                rsp_paddr <= (chk_fault == FLT_NONE)
                           ? {chk_frame, req_vaddr[PAGE_BITS-1:0]}
                           : {PA_W{1'b0}};
            end
        end
    end
endmodule

// File: rtl/pt_translator_chk.sv
// Protocol and response checks for pt_translator, bound to every instance.
// Assumes: synchronous active-low reset; all checks disabled while in reset.
module pt_translator_chk #(
    parameter int PAGE_BITS = 12,
    parameter int VPN_BITS  = 4,
    parameter int PFN_BITS  = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic [VPN_BITS+PAGE_BITS-1:0] req_vaddr,
    input logic                          rsp_valid,
    input logic [PFN_BITS+PAGE_BITS-1:0] rsp_paddr,
    input logic [2:0]                    rsp_fault
);
    // R8: every acceptance yields a response in the next cycle.
    a_r8_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R8: no response without an acceptance the cycle before.
    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

    // R1: a successful translation keeps the page offset.
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd0) |->
            rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0]));

    // R12: a faulted response carries a zero address.
    a_r12_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == '0);

    // R6: only defined fault codes appear.
    a_r6_fault_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault <= 3'd4);
endmodule

bind pt_translator pt_translator_chk #(
    .PAGE_BITS (PAGE_BITS),
    .VPN_BITS  (VPN_BITS),
    .PFN_BITS  (PFN_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/tb_pt_translator.sv
// Scoreboard bench: the driver pushes expected responses, the monitor pops
// and compares them at each falling edge where rsp_valid is high.
module tb_pt_translator;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE_BITS  = 12;
    localparam int VPN_BITS   = 4;
    localparam int CTX_BITS   = 2;
    localparam int PFN_BITS   = 8;
    localparam int IDX_BITS   = CTX_BITS + VPN_BITS;
    localparam int ENT_W      = PFN_BITS + 7;
    localparam int VA_W       = VPN_BITS + PAGE_BITS;
    localparam int PA_W       = PFN_BITS + PAGE_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [IDX_BITS-1:0] cfg_idx = '0;
    logic [ENT_W-1:0] cfg_entry = '0;
    logic ctx_we = 1'b0;
    logic [CTX_BITS-1:0] ctx_sel = '0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [1:0] req_access = '0;
    logic req_kernel = 1'b0;
    logic rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic [2:0] rsp_fault;

    int n_checks = 0;
    int n_fails  = 0;

    logic [ENT_W-1:0] model [1 << IDX_BITS];
    logic [CTX_BITS-1:0] cur_ctx = '0;
    logic [PA_W-1:0] q_pa [$];
    logic [2:0] q_flt [$];
    string q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_translator #(
        .PAGE_BITS (PAGE_BITS), .VPN_BITS (VPN_BITS),
        .CTX_BITS (CTX_BITS), .PFN_BITS (PFN_BITS)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_idx (cfg_idx), .cfg_entry (cfg_entry),
        .ctx_we (ctx_we), .ctx_sel (ctx_sel),
        .req_valid (req_valid), .req_ready (req_ready), .req_vaddr (req_vaddr),
        .req_access (req_access), .req_kernel (req_kernel),
        .rsp_valid (rsp_valid), .rsp_paddr (rsp_paddr), .rsp_fault (rsp_fault)
    );

    function automatic logic [ENT_W-1:0] mk(input logic p, v, e, u, r, w, x,
                                            input logic [PFN_BITS-1:0] f);
        return {p, v, e, u, r, w, x, f};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected result from the requirement rules (R1..R6, R12).
    task automatic predict(input logic [VA_W-1:0] va, input logic [1:0] acc,
                           input logic kern, output logic [PA_W-1:0] pa,
                           output logic [2:0] flt);
        logic [ENT_W-1:0] e;
        logic perm;
        e = model[{cur_ctx, va[PAGE_BITS +: VPN_BITS]}];
        case (acc)
            2'd0: perm = e[PFN_BITS+2];
            2'd1: perm = e[PFN_BITS+1];
            2'd2: perm = e[PFN_BITS];
            default: perm = 1'b0;
        endcase
        if (!kern && !e[PFN_BITS+3]) perm = 1'b0;
        if (!e[PFN_BITS+4]) flt = 3'd1;
        else if (!e[PFN_BITS+5]) flt = 3'd2;
        else if (!perm) flt = 3'd3;
        else if (!e[PFN_BITS+6]) flt = 3'd4;
        else flt = 3'd0;
        pa = (flt == 3'd0) ? {e[PFN_BITS-1:0], va[PAGE_BITS-1:0]} : '0;
    endtask

    // Driver: present one request for one cycle and record its expectation.
    task automatic send(input logic [VPN_BITS-1:0] vpn, input logic [PAGE_BITS-1:0] off,
                        input logic [1:0] acc, input logic kern, input string tag);
        logic [PA_W-1:0] pa;
        logic [2:0] flt;
        @(negedge clk);
        req_valid  = 1'b1;
        req_vaddr  = {vpn, off};
        req_access = acc;
        req_kernel = kern;
        predict(req_vaddr, acc, kern, pa, flt);
        q_pa.push_back(pa);
        q_flt.push_back(flt);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // R9: table write with a request pending in the same cycle.
    task automatic write_entry(input logic [CTX_BITS-1:0] c, input logic [VPN_BITS-1:0] vpn,
                               input logic [ENT_W-1:0] ent);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_idx = {c, vpn};
        cfg_entry = ent;
        req_valid = 1'b1;
        req_vaddr = {vpn, 12'h000};
        #1 check(req_ready == 1'b0, "R9 ready low during table write", req_ready, 0);
        model[{c, vpn}] = ent;
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b0;
    endtask

    // R7/R9: context reload with a request pending in the same cycle.
    task automatic set_ctx(input logic [CTX_BITS-1:0] c);
        @(negedge clk);
        ctx_we = 1'b1;
        ctx_sel = c;
        req_valid = 1'b1;
        #1 check(req_ready == 1'b0, "R9 ready low during context load", req_ready, 0);
        @(negedge clk);
        ctx_we = 1'b0;
        req_valid = 1'b0;
        cur_ctx = c;
    endtask

    // Monitor: compare each response pulse against the queue head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_pa.size() == 0) begin
                check(1'b0, "R8 response without request", 1, 0);
            end else begin
                logic [PA_W-1:0] epa;
                logic [2:0] ef;
                string t;
                epa = q_pa.pop_front();
                ef = q_flt.pop_front();
                t = q_tag.pop_front();
                check(rsp_fault == ef, {t, " fault"}, rsp_fault, ef);
                check(rsp_paddr == epa, {t, " paddr"}, rsp_paddr, epa);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << IDX_BITS); i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state.
        check(rsp_valid == 1'b0, "R10 rsp_valid after reset", rsp_valid, 0);
        check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
        send(4'd5, 12'h123, 2'd0, 1'b1, "R10 cleared table");
        idle(2);

        // Context 0: page 0 exists but unmapped (null guard).
        write_entry(2'd0, 4'd0, mk(1, 0, 1, 1, 1, 1, 1, 8'h11));
        send(4'd0, 12'h010, 2'd0, 1'b1, "R3 invalid page");
        // R9: write then next request sees it.
        write_entry(2'd0, 4'd2, mk(1, 1, 1, 1, 1, 0, 0, 8'hA5));
        send(4'd2, 12'hFFF, 2'd0, 1'b0, "R1 R9 user read after write");
        send(4'd2, 12'h004, 2'd1, 1'b0, "R4 write to read-only");
        send(4'd2, 12'h008, 2'd2, 1'b1, "R4 exec without x");
        send(4'd2, 12'h00C, 2'd3, 1'b1, "R4 reserved access");
        idle(1);
        write_entry(2'd0, 4'd3, mk(1, 1, 1, 0, 1, 1, 1, 8'h3C));
        send(4'd3, 12'h400, 2'd1, 1'b0, "R4 user on kernel page");
        send(4'd3, 12'h400, 2'd1, 1'b1, "R1 kernel on kernel page");
        // R6 priorities.
        write_entry(2'd0, 4'd4, mk(1, 1, 0, 1, 1, 1, 1, 8'h44));
        send(4'd4, 12'h000, 2'd0, 1'b1, "R6 missing beats others");
        write_entry(2'd0, 4'd6, mk(0, 0, 1, 0, 0, 0, 0, 8'h66));
        send(4'd6, 12'h000, 2'd0, 1'b0, "R6 invalid beats protection");
        write_entry(2'd0, 4'd7, mk(0, 1, 1, 1, 0, 1, 1, 8'h77));
        send(4'd7, 12'h000, 2'd0, 1'b1, "R6 protection beats absent");
        idle(2);

        // Context 1: 8 pages over 3 frames with aliasing and pages on disk.
        write_entry(2'd1, 4'd0, mk(1, 1, 1, 1, 1, 1, 0, 8'h01));
        write_entry(2'd1, 4'd3, mk(1, 1, 1, 1, 1, 1, 0, 8'h01));
        write_entry(2'd1, 4'd2, mk(1, 1, 1, 1, 1, 1, 0, 8'h02));
        write_entry(2'd1, 4'd7, mk(1, 1, 1, 1, 1, 1, 0, 8'h00));
        for (int p = 1; p < 7; p++)
            if (p != 2 && p != 3)
                write_entry(2'd1, p[3:0], mk(0, 1, 1, 1, 1, 1, 0, 8'h00));
        set_ctx(2'd1);
        // R8: back-to-back requests.
        send(4'd0, 12'hABC, 2'd0, 1'b0, "R11 page0 alias");
        send(4'd3, 12'hABC, 2'd1, 1'b0, "R11 page3 alias");
        send(4'd2, 12'h001, 2'd0, 1'b0, "R8 back-to-back");
        send(4'd7, 12'h002, 2'd0, 1'b0, "R8 back-to-back");
        send(4'd4, 12'h003, 2'd0, 1'b0, "R5 page on disk");
        send(4'd5, 12'h003, 2'd1, 1'b1, "R5 page on disk");
        send(4'd8, 12'h000, 2'd0, 1'b1, "R2 no entry");
        send(4'd0, 12'h000, 2'd2, 1'b1, "R4 exec denied");
        idle(2);

        // R7: same page through a different context.
        set_ctx(2'd0);
        send(4'd3, 12'h555, 2'd0, 1'b1, "R7 ctx0 page3");
        idle(1);
        set_ctx(2'd2);
        send(4'd3, 12'h555, 2'd0, 1'b1, "R7 ctx2 page3 empty");
        idle(3);

        check(q_pa.size() == 0, "R8 all responses seen", q_pa.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule